// File: doc/BRIEF.md
# Turbo-Mode Converter Serial Output Port

This block is a synthesizable stand-in for the digital side of a sampling converter whose serial output runs in turbo fashion. A host drives a convert strobe, a serial clock and a data-in line. The port answers with a serial data line and an output enable that together form a tri-state driver. A convert strobe rise, with the data-in line held high, starts a conversion. It captures a word from a parallel sample input and holds a busy interval of a set number of clock cycles. When that interval ends, the captured word moves into a second buffer. Serial reads always come from that second buffer, so the host clocks out the previous result while the current conversion is still running.

A read frame opens when the convert strobe falls. The most significant bit appears at once, and each later falling edge of the serial clock advances by one bit. The frame closes, and the line returns to high impedance, after the last bit's falling edge or at the next strobe rise, whichever comes first. Two quiet-interval rules are watched: a strobe fall that follows its rise too closely, and a strobe rise that follows the last serial clock fall too closely. Each breach raises a sticky error flag, and a clear input resets both flags.

The host pins are sampled on the system clock. Every event takes effect on the outputs one clock after the sample that shows it. The conversion sequencer has two states. CV_ACQUIRE moves to CV_CONVERT on an accepted start. CV_CONVERT moves back to CV_ACQUIRE when its counter runs out. The frame sequencer has three states. FR_IDLE moves to FR_SHIFT on a strobe fall. FR_SHIFT moves to FR_SPENT on the last bit's clock fall, and back to FR_IDLE on a strobe rise. FR_SPENT moves to FR_IDLE on a strobe rise.

Top module: `adc_turbo_sdo_port`

## Requirements
- R1: A strobe rise sampled while `sdi` is 1 and no conversion is running starts a conversion: `busy` reads 1 for exactly CONV_CYCLES consecutive samples. A rise sampled while `sdi` is 0 leaves `busy` at 0.
- R2: A strobe rise that arrives while `busy` is 1 neither lengthens the conversion nor replaces the captured word.
- R3: The word read out is the sample captured by the most recent conversion that finished before the strobe fall. After reset it is all zeros.
- R4: One clock after a strobe fall is sampled, `sdo_oe` is 1 and `sdo` carries bit DATA_W-1 of the word.
- R5: Each sampled serial clock fall inside a frame presents the next lower bit. Between falls, `sdo` holds its value.
- R6: The DATA_W-th serial clock fall drops `sdo_oe` to 0 one clock later. Further clock falls keep it at 0 until a new strobe fall.
- R7: A strobe rise during a frame drops `sdo_oe` to 0 one clock later.
- R8: A strobe fall sampled fewer than QUIET1_CYCLES clocks after the strobe rise sets `err_quiet1`. A fall at QUIET1_CYCLES clocks or later does not set it.
- R9: A strobe rise sampled fewer than QUIET2_CYCLES clocks after the latest serial clock fall sets `err_quiet2`. A rise at QUIET2_CYCLES clocks or later does not set it.
- R10: Both error flags stay set until a cycle with `err_clr` at 1 clears them. A breach in the same cycle as a clear leaves the flag set.
- R11: During reset, `sdo_oe`, `sdo`, `busy`, `err_quiet1` and `err_quiet2` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all host pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv | input | 1 | Convert strobe from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Data-in line; must be high for a strobe rise to start a conversion |
| sample_in | input | DATA_W | Parallel result captured at conversion start |
| err_clr | input | 1 | Clears both quiet-interval error flags |
| sdo | output | 1 | Serial data, MSB first; 0 while not driven |
| sdo_oe | output | 1 | Output enable for the tri-state serial data pad |
| busy | output | 1 | High during the conversion interval |
| err_quiet1 | output | 1 | Sticky flag: strobe fell too soon after its rise |
| err_quiet2 | output | 1 | Sticky flag: strobe rose too soon after a serial clock fall |

## Verification
The assertions assume the host pins change only between clock edges and stay stable long enough to be sampled. In particular, a strobe edge and a serial clock fall are treated as single sampled events, not as glitches shorter than a clock. The bench drives every pin one time unit after a rising clock edge and holds each level for at least a whole cycle. It never raises the strobe in the same sample as a serial clock fall, except in the deliberate quiet-interval breach. The conversion-length assertion also relies on the sequencer resting for at least one cycle between conversions. The stimulus keeps to that by waiting for `busy` to drop before each new start.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic {
        CV_ACQUIRE,
        CV_CONVERT
    } conv_state_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_SPENT
    } frame_state_t;

    localparam int PIN_CNV = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_COUNT = 2;

endpackage

// File: rtl/adc_pin_edges.sv
module adc_pin_edges #(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] pin_rise,
    output logic [PINS-1:0] pin_fall
);

    logic [PINS-1:0] level_q;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q[p] <= 1'b0;
            end else begin
                level_q[p] <= pin_level[p];
            end
        end

        always_comb begin
            pin_rise[p] = pin_level[p] & ~level_q[p];
            pin_fall[p] = ~pin_level[p] & level_q[p];
        end
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_port_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              sdi,
    input  logic [DATA_W-1:0] sample_in,
    output logic              busy,
    output logic [DATA_W-1:0] result_word
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    conv_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DATA_W-1:0] pending_q, result_q;
    logic             launch, finish;

    // next state
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            CV_ACQUIRE: begin
                if (start_pulse && sdi) begin
                    state_d = CV_CONVERT;
                    launch  = 1'b1;
                end
            end
            CV_CONVERT: begin
                if (cnt_q == '0) begin
                    state_d = CV_ACQUIRE;
                    finish  = 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CV_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and two-stage result buffers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pending_q <= '0;
            result_q  <= '0;
        end else begin
            if (launch) begin
                cnt_q     <= CNT_LOAD;
                pending_q <= sample_in;
            end else if (state_q == CV_CONVERT && !finish) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (finish) begin
                result_q <= pending_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q == CV_CONVERT);
        result_word = result_q;
    end

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
    import adc_port_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_open,
    input  logic              frame_abort,
    input  logic              bit_advance,
    input  logic [DATA_W-1:0] word_in,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    frame_state_t      state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              load_word, shift_word;

    // next state
    always_comb begin
        state_d    = state_q;
        load_word  = 1'b0;
        shift_word = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                if (frame_open) begin
                    state_d   = FR_SHIFT;
                    load_word = 1'b1;
                end
            end
            FR_SHIFT: begin
                if (frame_abort) begin
                    state_d = FR_IDLE;
                end else if (bit_advance) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = FR_SPENT;
                    end else begin
                        shift_word = 1'b1;
                    end
                end
            end
            FR_SPENT: begin
                if (frame_abort) begin
                    state_d = FR_IDLE;
                end
            end
            default: state_d = FR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // shift register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (load_word) begin
            shreg_q <= word_in;
            idx_q   <= '0;
        end else if (shift_word) begin
            shreg_q <= shreg_q << 1;
            idx_q   <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sdo_oe = (state_q == FR_SHIFT);
        sdo    = sdo_oe ? shreg_q[DATA_W-1] : 1'b0;
    end

endmodule

// File: rtl/adc_quiet_window.sv
module adc_quiet_window #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic probe,
    output logic violation
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (arm) begin
            remain_q <= CNT_LOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    always_comb begin
        violation = probe && (arm || (remain_q != '0));
    end

endmodule

// File: rtl/adc_quiet_monitor.sv
module adc_quiet_monitor #(
    parameter int QUIET1_CYCLES = 4,
    parameter int QUIET2_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_rise,
    input  logic cnv_fall,
    input  logic sck_fall,
    input  logic err_clr,
    output logic err_quiet1,
    output logic err_quiet2
);

    logic viol1, viol2;
    logic flag1_q, flag2_q;

    adc_quiet_window #(.HOLD_CYCLES(QUIET1_CYCLES)) u_win_rise_to_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (cnv_rise),
        .probe    (cnv_fall),
        .violation(viol1)
    );

    adc_quiet_window #(.HOLD_CYCLES(QUIET2_CYCLES)) u_win_clock_to_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (sck_fall),
        .probe    (cnv_rise),
        .violation(viol2)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
        end else begin
            flag1_q <= (flag1_q & ~err_clr) | viol1;
            flag2_q <= (flag2_q & ~err_clr) | viol2;
        end
    end

    always_comb begin
        err_quiet1 = flag1_q;
        err_quiet2 = flag2_q;
    end

endmodule

// File: rtl/adc_turbo_sdo_port.sv
module adc_turbo_sdo_port
    import adc_port_pkg::*;
#(
    parameter int DATA_W        = 18,
    parameter int CONV_CYCLES   = 40,
    parameter int QUIET1_CYCLES = 4,
    parameter int QUIET2_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv,
    input  logic              sck,
    input  logic              sdi,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              err_clr,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy,
    output logic              err_quiet1,
    output logic              err_quiet2
);

    logic [PIN_COUNT-1:0] pins, rises, falls;
    logic                 cnv_rise, cnv_fall, sck_fall;
    logic [DATA_W-1:0]    held_word;

    always_comb begin
        pins          = '0;
        pins[PIN_CNV] = cnv;
        pins[PIN_SCK] = sck;
        cnv_rise      = rises[PIN_CNV];
        cnv_fall      = falls[PIN_CNV];
        sck_fall      = falls[PIN_SCK];
    end

    adc_pin_edges #(.PINS(PIN_COUNT)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_level(pins),
        .pin_rise (rises),
        .pin_fall (falls)
    );

    adc_conv_sequencer #(
        .DATA_W     (DATA_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(cnv_rise),
        .sdi        (sdi),
        .sample_in  (sample_in),
        .busy       (busy),
        .result_word(held_word)
    );

    adc_frame_shifter #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_open (cnv_fall),
        .frame_abort(cnv_rise),
        .bit_advance(sck_fall),
        .word_in    (held_word),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    adc_quiet_monitor #(
        .QUIET1_CYCLES(QUIET1_CYCLES),
        .QUIET2_CYCLES(QUIET2_CYCLES)
    ) u_quiet (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnv_rise  (cnv_rise),
        .cnv_fall  (cnv_fall),
        .sck_fall  (sck_fall),
        .err_clr   (err_clr),
        .err_quiet1(err_quiet1),
        .err_quiet2(err_quiet2)
    );

endmodule

// File: rtl/adc_turbo_sdo_port_chk.sv
module adc_turbo_sdo_port_chk #(
    parameter int CONV_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic sdi,
    input logic err_clr,
    input logic sdo,
    input logic sdo_oe,
    input logic busy,
    input logic err_quiet1,
    input logic err_quiet2,
    input logic cnv_rise,
    input logic sck_fall
);

    localparam int RUN_W = $clog2(CONV_CYCLES + 2);

    logic [RUN_W-1:0] busy_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    assert_conv_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cnv_rise) && $past(sdi)));

    assert_conv_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run_q < RUN_W'(CONV_CYCLES)));

    assert_open_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !$past(cnv));

    assert_hold_between_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !sck_fall && !cnv_rise) |=> (sdo_oe && $stable(sdo)));

    assert_release_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && cnv_rise) |=> !sdo_oe);

    assert_sticky_quiet1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_quiet1 && !err_clr) |=> err_quiet1);

    assert_sticky_quiet2_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_quiet2 && !err_clr) |=> err_quiet2);

endmodule

bind adc_turbo_sdo_port adc_turbo_sdo_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv       (cnv),
    .sdi       (sdi),
    .err_clr   (err_clr),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .busy      (busy),
    .err_quiet1(err_quiet1),
    .err_quiet2(err_quiet2),
    .cnv_rise  (cnv_rise),
    .sck_fall  (sck_fall)
);

// File: tb/adc_turbo_sdo_port_test.sv
`timescale 1ns/1ps
module adc_turbo_sdo_port_test;

    localparam int DW    = 18;
    localparam int CONV  = 40;
    localparam int Q1    = 4;
    localparam int Q2    = 3;
    localparam int NVEC  = 6;

    // {sample started by this frame's rise, word expected out of this frame (R3)}
    localparam logic [2*DW-1:0] VEC [NVEC] = '{
        {18'h3FFFF, 18'h00000},
        {18'h00000, 18'h3FFFF},
        {18'h2AAAA, 18'h00000},
        {18'h15555, 18'h2AAAA},
        {18'h20001, 18'h15555},
        {18'h1E0F3, 18'h20001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnv = 1'b0;
    logic          sck = 1'b0;
    logic          sdi = 1'b1;
    logic          err_clr = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic          sdo, sdo_oe, busy, err_quiet1, err_quiet2;

    int checks = 0;
    int errors = 0;
    int busy_seen = 0;
    int wd_cycles = 0;

    always #2 clk = ~clk;

    adc_turbo_sdo_port #(
        .DATA_W       (DW),
        .CONV_CYCLES  (CONV),
        .QUIET1_CYCLES(Q1),
        .QUIET2_CYCLES(Q2)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnv       (cnv),
        .sck       (sck),
        .sdi       (sdi),
        .sample_in (sample_in),
        .err_clr   (err_clr),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .busy      (busy),
        .err_quiet1(err_quiet1),
        .err_quiet2(err_quiet2)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (busy) busy_seen++;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sck_pulse();
        sck = 1'b1; tick();
        sck = 1'b0; tick();
    endtask

    task automatic do_frame(input logic [DW-1:0] smp, output logic [DW-1:0] got);
        sample_in = smp; sdi = 1'b1; cnv = 1'b1; tick();
        repeat (Q1 - 1) tick();
        cnv = 1'b0; tick();
        chk("R4", "oe after strobe fall", {31'd0, sdo_oe}, 32'd1);
        got = '0;
        got[DW-1] = sdo;
        for (int b = DW - 2; b >= 0; b--) begin
            sck_pulse();
            got[b] = sdo;
        end
        sck_pulse();
        chk("R6", "oe after last clock fall", {31'd0, sdo_oe}, 32'd0);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 1000 && busy; g++) tick();
        repeat (Q2) tick();
    endtask

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 150000) begin
            errors++;
            $display("FAIL watchdog R11 actual=%0d expected=done", wd_cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got;
        logic [DW-1:0] x_word;
        x_word = 18'h0C3A5;

        repeat (3) tick();
        chk("R11", "reset oe", {31'd0, sdo_oe}, 32'd0);
        chk("R11", "reset sdo", {31'd0, sdo}, 32'd0);
        chk("R11", "reset busy", {31'd0, busy}, 32'd0);
        chk("R11", "reset flags", {30'd0, err_quiet1, err_quiet2}, 32'd0);
        rst_n = 1'b1;
        tick();

        // R3 R5: table of frames
        for (int i = 0; i < NVEC; i++) begin
            do_frame(VEC[i][2*DW-1:DW], got);
            chk("R3 R5", "frame word", {14'd0, got}, {14'd0, VEC[i][DW-1:0]});
            wait_idle();
        end
        chk("R8", "no flag at exact quiet1", {31'd0, err_quiet1}, 32'd0);
        chk("R9", "no flag with long gap", {31'd0, err_quiet2}, 32'd0);

        // R6: extra clock fall after a spent frame
        sck_pulse();
        chk("R6", "oe after extra clock fall", {31'd0, sdo_oe}, 32'd0);
        repeat (Q2) tick();

        // R1 R2 R7: conversion with a mid-frame strobe rise
        busy_seen = 0;
        sample_in = x_word; sdi = 1'b1; cnv = 1'b1; tick();
        repeat (Q1 - 1) tick();
        cnv = 1'b0; tick();
        repeat (5) sck_pulse();
        chk("R5", "oe mid frame", {31'd0, sdo_oe}, 32'd1);
        repeat (Q2) tick();
        sample_in = 18'h3F00F; cnv = 1'b1; tick();
        chk("R7", "oe after strobe rise mid frame", {31'd0, sdo_oe}, 32'd0);
        chk("R2", "busy kept through extra rise", {31'd0, busy}, 32'd1);
        wait_idle();
        chk("R1", "busy length", busy_seen, CONV);
        chk("R2", "busy length unchanged by extra rise", busy_seen, CONV);
        cnv = 1'b0; tick();
        do_frame(18'h01234, got);
        chk("R2", "word not replaced", {14'd0, got}, {14'd0, x_word});
        wait_idle();

        // R1: start with sdi low
        sdi = 1'b0; cnv = 1'b1; tick();
        chk("R1", "no start when sdi low", {31'd0, busy}, 32'd0);
        repeat (Q1) tick();
        cnv = 1'b0; tick();
        repeat (2) tick();

        // R8 R10: early strobe fall
        cnv = 1'b1; tick();
        cnv = 1'b0; tick();
        chk("R8", "quiet1 flag", {31'd0, err_quiet1}, 32'd1);
        chk("R9", "quiet2 untouched", {31'd0, err_quiet2}, 32'd0);
        repeat (5) tick();
        chk("R10", "quiet1 sticky", {31'd0, err_quiet1}, 32'd1);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk("R10", "quiet1 cleared", {31'd0, err_quiet1}, 32'd0);
        cnv = 1'b1; tick();
        err_clr = 1'b1; cnv = 1'b0; tick(); err_clr = 1'b0;
        chk("R10", "breach beats clear", {31'd0, err_quiet1}, 32'd1);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk("R10", "quiet1 cleared again", {31'd0, err_quiet1}, 32'd0);

        // R9: early strobe rise after clock fall
        repeat (Q1) tick();
        sck_pulse();
        cnv = 1'b1; tick();
        chk("R9", "quiet2 flag", {31'd0, err_quiet2}, 32'd1);
        chk("R8", "quiet1 untouched", {31'd0, err_quiet1}, 32'd0);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk("R10", "quiet2 cleared", {31'd0, err_quiet2}, 32'd0);
        repeat (Q1) tick();
        cnv = 1'b0; tick();
        sck_pulse();
        repeat (Q2 - 1) tick();
        cnv = 1'b1; tick();
        chk("R9", "no flag at exact quiet2", {31'd0, err_quiet2}, 32'd0);
        repeat (4) tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule